// File: doc/BRIEF.md
# Error Message Queue with Severity Status

This block sits on the receive side of a root port. Downstream devices send error messages, and each message carries a severity code and a 16-bit requester ID. The block keeps the requester IDs in a small first-in first-out queue. It shows the oldest entry in a head register that software reads. Software removes that entry by writing a fixed all-ones pattern to the same address.

Every message with a legal severity also sets a sticky bit for that severity in a status register. Software clears these bits by writing ones to them. A second register enables individual status bits, and the block raises one interrupt line whenever an enabled status bit is set. When the queue is full and a message arrives, the message is discarded and a sticky overflow status bit records the loss.

The register port is a plain single-cycle write strobe with an address. Reads are combinational from the current register state.

Top module: `errq_top`

## Requirements
- R1: After reset the queue is empty, and all four addresses read 0: head at address 0, status at address 1, enable at address 2, and the unused address 3. The interrupt output is 0.
- R2: At address 0 the block reads bit 18 = 1 and bits 15:0 = the requester ID of the oldest queued message, with every other bit 0. When the queue is empty, the whole word reads 0. A message shows up in the queue one cycle after it arrives.
- R3: A write of 32'hFFFF_FFFF to address 0 removes the oldest entry on the next clock edge. A write of any other value to address 0 changes nothing. A removing write while the queue is empty has no effect.
- R4: Severity codes 0, 1 and 2 (correctable, non-fatal, fatal) set status bits 9, 10 and 11 respectively on the clock edge where the message is accepted. Code 3 is ignored: it is not queued and sets no bit.
- R5: Writing to address 1 clears each status bit among bits 12:9 whose write-data bit is 1 and leaves the other bits unchanged. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R6: The enable register at address 2 takes the full 32-bit write data and reads it back. The interrupt output is the OR of (status & enable), so writing 0 to the enable register forces the interrupt low.
- R7: The queue holds 8 entries. A message that arrives while the queue is full, with no removal in the same cycle, is discarded, leaves the queue unchanged, and sets sticky status bit 12.
- R8: A removal and an arrival in the same cycle leave the entry count unchanged. The old head is removed and the new ID is placed at the tail, and this also applies when the queue is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_vld | input | 1 | An error message arrives this cycle |
| msg_sev | input | 2 | Severity code of the message (0 corr, 1 non-fatal, 2 fatal, 3 reserved) |
| msg_rid | input | 16 | Requester ID of the message |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 head, 1 status, 2 enable) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the entry count never goes above the depth and that a discarded arrival or a simultaneous arrival and removal leaves the count unchanged. They also check that an accepted message sets its status bit on the next cycle, that a clear with no competing set takes effect, that a zero enable write silences the interrupt, and that an empty queue reads as zero. Only the bench scenarios show first-in first-out order across fills and drains, that writes to the head address other than all ones are ignored, that reserved severity codes are ignored, and that the overflow bit stays set until software clears it.

// File: rtl/errq_pkg.sv
package errq_pkg;
  localparam int REG_W     = 32;
  localparam int RID_W     = 16;
  localparam int VALID_BIT = 18;
  localparam int DEC_BASE  = 9;
  localparam int NUM_SEV   = 3;
  localparam int NUM_SRC   = NUM_SEV + 1;  // severities plus overflow
  localparam logic [REG_W-1:0] POP_KEY = '1;

  typedef enum logic [1:0] {
    SEV_COR = 2'd0,
    SEV_NF  = 2'd1,
    SEV_FAT = 2'd2,
    SEV_RSV = 2'd3
  } sev_e;

  typedef enum logic [1:0] {
    A_HEAD = 2'd0,
    A_DEC  = 2'd1,
    A_MASK = 2'd2,
    A_NONE = 2'd3
  } addr_e;

  function automatic logic [NUM_SEV-1:0] sev_onehot(logic [1:0] s);
    logic [NUM_SEV-1:0] v;
    v = '0;
    if (s != SEV_RSV) v[s] = 1'b1;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] head_word(logic vld, logic [RID_W-1:0] rid);
    logic [REG_W-1:0] w;
    w = '0;
    if (vld) begin
      w[VALID_BIT]   = 1'b1;
      w[RID_W-1:0]   = rid;
    end
    return w;
  endfunction

  function automatic logic [REG_W-1:0] dec_word(logic [NUM_SRC-1:0] d);
    logic [REG_W-1:0] w;
    w = '0;
    w[DEC_BASE +: NUM_SRC] = d;
    return w;
  endfunction

  function automatic logic [NUM_SRC-1:0] dec_field(logic [REG_W-1:0] w);
    return w[DEC_BASE +: NUM_SRC];
  endfunction
endpackage

// File: rtl/errq_fifo.sv
module errq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_req,
  input  logic [W-1:0] din,
  input  logic         pop_req,
  output logic         head_valid,
  output logic [W-1:0] head_data,
  output logic         drop
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push_req && (!full || pop_ok);
  assign drop    = push_req && full && !pop_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  assign head_valid = !empty;
  assign head_data  = empty ? '0 : mem[rd_ptr];

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  p_drop_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(count));
  p_pushpop_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && head_valid) |=> $stable(count));
endmodule

// File: rtl/errq_status.sv
module errq_status
  import errq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  input  logic               mask_wr,
  input  logic [REG_W-1:0]   mask_din,
  output logic [NUM_SRC-1:0] dec_q,
  output logic [REG_W-1:0]   mask_q,
  output logic               irq
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          dec_q[i] <= 1'b0;
      else if (set_vec[i]) dec_q[i] <= 1'b1;
      else if (clr_vec[i]) dec_q[i] <= 1'b0;
    end

    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> dec_q[i]);
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !dec_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_din;
  end

  assign irq = |(dec_word(dec_q) & mask_q);

  p_mask_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_din == '0) |=> !irq);
endmodule

// File: rtl/errq_top.sv
module errq_top
  import errq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msg_vld,
  input  logic [1:0]  msg_sev,
  input  logic [15:0] msg_rid,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  logic [NUM_SEV-1:0] sev_hot;
  logic               push_req, pop_req, drop;
  logic               head_valid;
  logic [RID_W-1:0]   head_data;
  logic [NUM_SRC-1:0] set_vec, clr_vec, dec_q;
  logic [REG_W-1:0]   mask_q;
  logic               dec_wr, mask_wr;

  assign sev_hot  = msg_vld ? sev_onehot(msg_sev) : '0;
  assign push_req = |sev_hot;
  assign pop_req  = reg_wr && (reg_addr == A_HEAD) && (reg_wdata == POP_KEY);
  assign dec_wr   = reg_wr && (reg_addr == A_DEC);
  assign mask_wr  = reg_wr && (reg_addr == A_MASK);
  assign set_vec  = {drop, sev_hot};
  assign clr_vec  = dec_wr ? dec_field(reg_wdata) : '0;

  errq_fifo #(.DEPTH(DEPTH), .W(RID_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (push_req),
    .din        (msg_rid),
    .pop_req    (pop_req),
    .head_valid (head_valid),
    .head_data  (head_data),
    .drop       (drop)
  );

  errq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .mask_wr  (mask_wr),
    .mask_din (reg_wdata),
    .dec_q    (dec_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  always_comb begin
    unique case (reg_addr)
      A_HEAD:  reg_rdata = head_word(head_valid, head_data);
      A_DEC:   reg_rdata = dec_word(dec_q);
      A_MASK:  reg_rdata = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  p_empty_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_HEAD && !head_valid) |-> reg_rdata == '0);
endmodule

// File: tb/errq_top_tb.sv
module errq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_vld = 1'b0;
  logic [1:0]  msg_sev = '0;
  logic [15:0] msg_rid = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] m_q[$];
  logic [31:0] m_dec = '0;
  logic [31:0] m_mask = '0;

  errq_top u_dut (
    .clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg_sev(msg_sev),
    .msg_rid(msg_rid), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete();
      m_dec = '0;
      m_mask = '0;
    end else begin
      bit pop, push, dropped;
      pop  = reg_wr && reg_addr == 2'd0 && reg_wdata == 32'hFFFF_FFFF && m_q.size() > 0;
      push = msg_vld && msg_sev != 2'd3;
      dropped = push && m_q.size() == 8 && !pop;
      if (reg_wr && reg_addr == 2'd1) m_dec = m_dec & ~(reg_wdata & 32'h0000_1E00);
      if (push) m_dec[9 + msg_sev] = 1'b1;
      if (dropped) m_dec[12] = 1'b1;
      if (reg_wr && reg_addr == 2'd2) m_mask = reg_wdata;
      if (pop) void'(m_q.pop_front());
      if (push && !dropped) m_q.push_back(msg_rid);
    end
  end

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return (m_q.size() > 0) ? (32'h0004_0000 | {16'h0, m_q[0]}) : 32'h0;
      2'd1: return m_dec;
      2'd2: return m_mask;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs, compare against model before the edge
  task automatic step(string req, bit vld, logic [1:0] sev, logic [15:0] rid,
                      bit wr, logic [1:0] addr, logic [31:0] wd);
    @(negedge clk);
    msg_vld = vld; msg_sev = sev; msg_rid = rid;
    reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    #1;
    check(req, reg_rdata, m_read(addr));
    check("R6", {31'h0, irq}, {31'h0, |(m_dec & m_mask)});
  endtask

  task automatic rd(string req, logic [1:0] addr);
    step(req, 0, 2'd0, 16'h0, 0, addr, 32'h0);
  endtask

  task automatic peek(string req, logic [1:0] addr, logic [31:0] exp);
    @(negedge clk);
    msg_vld = 0; reg_wr = 0; reg_addr = addr;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    #(20 * 20000);
    $display("FAIL watchdog: actual=timeout expected=finish");
    n_errors++;
    n_checks++;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    peek("R1", 2'd0, 32'h0);
    peek("R1", 2'd1, 32'h0);
    peek("R1", 2'd2, 32'h0);
    peek("R1", 2'd3, 32'h0);
    check("R1", {31'h0, irq}, 32'h0);

    // R6: enable everything
    step("R6", 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF);
    rd("R6", 2'd2);

    // R2/R4: three severities
    step("R4", 1, 2'd0, 16'hA001, 0, 2'd0, 0);
    step("R2", 1, 2'd1, 16'hA002, 0, 2'd0, 0);
    step("R2", 1, 2'd2, 16'hA003, 0, 2'd0, 0);
    peek("R2", 2'd0, 32'h0004_A001);
    peek("R4", 2'd1, 32'h0000_0E00);

    // R5: clear bit 9 only, then clear 10 while a non-fatal arrives
    step("R5", 0, 0, 0, 1, 2'd1, 32'h0000_0200);
    peek("R5", 2'd1, 32'h0000_0C00);
    step("R5", 1, 2'd1, 16'hA004, 1, 2'd1, 32'h0000_0400);
    peek("R5", 2'd1, 32'h0000_0C00);

    // R3: non-key write ignored, then key pops
    step("R3", 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFE);
    peek("R3", 2'd0, 32'h0004_A001);
    step("R3", 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
    peek("R3", 2'd0, 32'h0004_A002);
    for (int i = 0; i < 5; i++) step("R3", 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
    peek("R3", 2'd0, 32'h0);

    // R4: reserved severity ignored
    step("R5", 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF);
    step("R4", 1, 2'd3, 16'hBEEF, 0, 2'd0, 0);
    peek("R4", 2'd0, 32'h0);
    peek("R4", 2'd1, 32'h0);

    // R7: fill past depth
    for (int i = 0; i < 10; i++) step("R7", 1, 2'd0, 16'hC000 + 16'(i), 0, 2'd1, 0);
    peek("R7", 2'd1, 32'h0000_1200);
    peek("R7", 2'd0, 32'h0004_C000);

    // R8: push and pop together while full
    step("R8", 1, 2'd2, 16'hD00D, 1, 2'd0, 32'hFFFF_FFFF);
    peek("R8", 2'd0, 32'h0004_C001);
    step("R8", 1, 2'd2, 16'hD00E, 0, 2'd0, 0);
    peek("R7", 2'd1, 32'h0000_1A00);
    for (int i = 0; i < 7; i++) step("R8", 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
    peek("R8", 2'd0, 32'h0004_D00D);

    // R6: enable zero silences
    step("R6", 0, 0, 0, 1, 2'd2, 32'h0);
    peek("R6", 2'd2, 32'h0);
    check("R6", {31'h0, irq}, 32'h0);
    step("R6", 0, 0, 0, 1, 2'd2, 32'h0000_0800);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      step("R8", $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
           16'($urandom), k < 3, (k == 0) ? 2'd0 : 2'($urandom_range(0, 3)),
           (k == 0 || $urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF : $urandom);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule